// File: doc/BRIEF.md
# I2C Slave Engine With State Reporting

This block is the target side of a two-wire serial bus. It takes the raw clock and data lines from the pads, brings them into the system clock domain and filters out short pulses. It then finds start, repeated start and stop conditions and follows the bit stream. It recognises either a 7-bit address or a two-byte 10-bit address. Once addressed, it receives bytes from the bus master or sends bytes to it, depending on the read/write bit that ends the address. The block never drives a line high. Its only bus output is a low-enable for the data line, and the pad cell turns that into an open-drain pull.

On the host side the block takes its own address, a 10-bit mode select, a transmit byte with a valid flag, and a level that refuses the next received byte. It returns each received byte with a one-cycle strobe and pulses an acknowledge when it takes a transmit byte. It also reports its position in the protocol as an 8-bit code. The upper nibble is the major state. The lower nibble is the bit position inside a byte, where 8 is the acknowledge bit; outside byte states it is zero. Major codes: 0x0 idle or disabled, 0x1 start seen, 0x2 not addressed, 0x3 waiting after a refused or final byte, 0x8 sending data, 0x9 receiving data, 0xA first address byte, 0xB second address byte.

Top module: `i2cs_engine`

## Requirements
- R1: While `enable` is low the state code is 0x00 one cycle later, `sda_pull` stays low and bus activity is ignored. After reset the state code is 0x00.
- R2: A START in any state gives code 0x10, and a repeated START in any state also gives 0x10. A STOP in any state, including in the middle of a byte, gives 0x00.
- R3: In the byte states (codes 0x8_ to 0xB_) the low nibble is the index of the current bit, 0 for the first (most significant) bit up to 7. It is 8 during the acknowledge bit. Outside these states the low nibble is 0.
- R4: With `ten_bit_en` low, a first byte whose upper seven bits equal `own_addr[6:0]` is acknowledged (SDA pulled low in the ninth bit). Bit 0 of that byte then selects receive (0, code 0x9_) or transmit (1, code 0x8_).
- R5: A first byte that does not match gives code 0x20 from the acknowledge bit on. In that state the block never pulls SDA and never strobes `rx_strobe` until the next START or STOP.
- R6: With `ten_bit_en` high, a write header 11110, `own_addr[9:8]`, 0 is acknowledged and leads to code 0xB_. A second byte equal to `own_addr[7:0]` is acknowledged and leads to receive (0x9_). A header with other upper bits, or a wrong second byte, leads to 0x20.
- R7: In 10-bit mode a read header 11110, `own_addr[9:8]`, 1 is acknowledged and leads to transmit only if the full 10-bit address matched earlier in the same transaction (no STOP since). Otherwise it leads to 0x20.
- R8: Each received data byte appears on `rx_byte` with a one-cycle `rx_strobe`. It is acknowledged unless `nack_next` is high at the end of its eighth bit. In that case it is not acknowledged and the code becomes 0x30 after the acknowledge bit.
- R9: In transmit, bytes go out most significant bit first. A byte is taken from `tx_byte` when the transmit state is entered and after each master acknowledge. `tx_taken` pulses for a byte taken while `tx_valid` is high. With `tx_valid` low the byte 0xFF is sent and `tx_taken` stays low.
- R10: In transmit, a master NACK on the ninth bit gives code 0x30. A master ACK continues with the next byte at code 0x80.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces the idle state |
| scl_in | input | 1 | Raw bus clock from the pad |
| sda_in | input | 1 | Raw bus data from the pad |
| ten_bit_en | input | 1 | Selects 10-bit addressing |
| own_addr | input | 10 | Own bus address (7-bit mode uses bits 6:0) |
| tx_byte | input | 8 | Next byte to send |
| tx_valid | input | 1 | `tx_byte` holds a fresh byte |
| tx_taken | output | 1 | One-cycle pulse when a valid transmit byte is loaded |
| rx_byte | output | 8 | Last received data byte |
| rx_strobe | output | 1 | One-cycle pulse when `rx_byte` is updated |
| nack_next | input | 1 | Refuse the data byte now being received |
| sda_pull | output | 1 | Pull SDA low when high |
| state_code | output | 8 | Major state (upper nibble) and bit index (lower nibble) |

## Verification
The hardest case to reach from the ports is the 10-bit read. The read header is only accepted after a write header, a matching second byte and a repeated START, all without a STOP in between. The same header must be refused after a STOP or without the earlier match. The stimulus runs that full sequence on purpose and follows it with the same read header sent cold, plus a mismatched second byte. Random 7-bit write transactions with matching and non-matching addresses and random payloads come before these directed cases. Each bit's high phase is checked against the expected state code, so every substate is observed.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 4;
  localparam int ADDR_W  = 10;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(BYTE_W);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'h0,
    ST_START = 4'h1,
    ST_BYST  = 4'h2,
    ST_WAIT  = 4'h3,
    ST_TXD   = 4'h8,
    ST_RXD   = 4'h9,
    ST_AD1   = 4'hA,
    ST_AD2   = 4'hB
  } major_e;

  // Byte-carrying states all have the top bit of the major code set.
  function automatic logic is_byte_state(input major_e m);
    return m[3];
  endfunction

  function automatic logic [7:0] pack_code(input major_e m, input logic [CNT_W-1:0] c);
    return {m, is_byte_state(m) ? c : {CNT_W{1'b0}}};
  endfunction

  function automatic logic hit7(input logic [BYTE_W-1:0] b, input logic [ADDR_W-1:0] own);
    return b[7:1] == own[6:0];
  endfunction

  function automatic logic hdr10(input logic [BYTE_W-1:0] b, input logic [ADDR_W-1:0] own);
    return (b[7:3] == TEN_PREFIX) && (b[2:1] == own[9:8]);
  endfunction

endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN - 1);

  logic       s1, s2;
  logic [CW-1:0] run;

  // Two-flop synchronizer, then the output follows only after the
  // synchronized level has differed from it for FILT_LEN cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      clean <= 1'b1;
      run   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == clean) begin
        run <= '0;
      end else if (run == LIMIT) begin
        clean <= s2;
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  // Data edges while the clock stays high are bus conditions.
  assign start_evt = scl & scl_d & sda_d & ~sda;
  assign stop_evt  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/i2cs_slave_fsm.sv
module i2cs_slave_fsm
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_now,
  input  logic              ten_bit_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_taken,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_strobe,
  input  logic              nack_next,
  output logic              sda_pull,
  output logic [7:0]        state_code
);
  major_e            major, after_ack;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_q;
  logic              ten_ok;
  logic              mack_q;

  logic              last_bit, ack_slot, in_rx_like;
  logic [BYTE_W-1:0] next_tx;

  assign last_bit   = (cnt == LAST_BIT);
  assign ack_slot   = (cnt == ACK_IDX);
  assign in_rx_like = (major == ST_AD1) || (major == ST_AD2) || (major == ST_RXD);
  assign next_tx    = tx_valid ? tx_byte : {BYTE_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      major     <= ST_IDLE;
      after_ack <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      ack_q     <= 1'b0;
      ten_ok    <= 1'b0;
      mack_q    <= 1'b1;
      rx_byte   <= '0;
      rx_strobe <= 1'b0;
      tx_taken  <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      tx_taken  <= 1'b0;
      if (!enable || stop_evt) begin
        major  <= ST_IDLE;
        cnt    <= '0;
        ack_q  <= 1'b0;
        ten_ok <= 1'b0;
      end else if (start_evt) begin
        major <= ST_START;
        cnt   <= '0;
        ack_q <= 1'b0;
      end else begin
        case (major)
          ST_START: begin
            if (scl_fall) begin
              major <= ST_AD1;
              cnt   <= '0;
            end
          end
          ST_AD1, ST_AD2, ST_RXD: begin
            if (scl_rise && !ack_slot) shreg <= {shreg[BYTE_W-2:0], sda_now};
            if (scl_fall) begin
              if (last_bit) begin
                cnt <= ACK_IDX;
                case (major)
                  ST_AD1: begin
                    if (!ten_bit_en) begin
                      if (hit7(shreg, own_addr)) begin
                        ack_q     <= 1'b1;
                        after_ack <= shreg[0] ? ST_TXD : ST_RXD;
                      end else begin
                        major <= ST_BYST;
                        cnt   <= '0;
                      end
                    end else if (hdr10(shreg, own_addr) && !shreg[0]) begin
                      ack_q     <= 1'b1;
                      after_ack <= ST_AD2;
                      ten_ok    <= 1'b0;
                    end else if (hdr10(shreg, own_addr) && ten_ok) begin
                      ack_q     <= 1'b1;
                      after_ack <= ST_TXD;
                    end else begin
                      major <= ST_BYST;
                      cnt   <= '0;
                    end
                  end
                  ST_AD2: begin
                    if (shreg == own_addr[BYTE_W-1:0]) begin
                      ack_q     <= 1'b1;
                      after_ack <= ST_RXD;
                      ten_ok    <= 1'b1;
                    end else begin
                      major <= ST_BYST;
                      cnt   <= '0;
                    end
                  end
                  default: begin
                    rx_byte   <= shreg;
                    rx_strobe <= 1'b1;
                    ack_q     <= !nack_next;
                    after_ack <= nack_next ? ST_WAIT : ST_RXD;
                  end
                endcase
              end else if (ack_slot) begin
                cnt   <= '0;
                ack_q <= 1'b0;
                major <= after_ack;
                if (after_ack == ST_TXD) begin
                  shreg    <= next_tx;
                  tx_taken <= tx_valid;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_TXD: begin
            if (scl_rise && ack_slot) mack_q <= sda_now;
            if (scl_fall) begin
              if (last_bit) begin
                cnt <= ACK_IDX;
              end else if (ack_slot) begin
                cnt <= '0;
                if (!mack_q) begin
                  shreg    <= next_tx;
                  tx_taken <= tx_valid;
                end else begin
                  major <= ST_WAIT;
                end
              end else begin
                cnt   <= cnt + 1'b1;
                shreg <= {shreg[BYTE_W-2:0], 1'b1};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull   = (in_rx_like && ack_slot && ack_q) ||
                      ((major == ST_TXD) && !ack_slot && !shreg[BYTE_W-1]);
  assign state_code = pack_code(major, cnt);
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              ten_bit_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_taken,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_strobe,
  input  logic              nack_next,
  output logic              sda_pull,
  output logic [7:0]        state_code
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines, clean_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    i2cs_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_lines[g]),
      .clean (clean_lines[g])
    );
  end

  assign scl_f = clean_lines[1];
  assign sda_f = clean_lines[0];

  i2cs_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (scl_f),
    .sda       (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2cs_slave_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .sda_now    (sda_f),
    .ten_bit_en (ten_bit_en),
    .own_addr   (own_addr),
    .tx_byte    (tx_byte),
    .tx_valid   (tx_valid),
    .tx_taken   (tx_taken),
    .rx_byte    (rx_byte),
    .rx_strobe  (rx_strobe),
    .nack_next  (nack_next),
    .sda_pull   (sda_pull),
    .state_code (state_code)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       start_evt,
  input logic       stop_evt,
  input logic [7:0] state_code,
  input logic       sda_pull,
  input logic       rx_strobe,
  input logic       tx_taken
);
  a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state_code == 8'h00) && !sda_pull);

  a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stop_evt) |=> (state_code == 8'h00));

  a_r2_start_code: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start_evt && !stop_evt) |=> (state_code == 8'h10));

  a_r3_sub_max: assert property (@(posedge clk) disable iff (!rst_n)
    state_code[3:0] <= 4'd8);

  a_r3_nonbyte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !state_code[7] |-> (state_code[3:0] == 4'd0));

  a_r5_bystander_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code[7:4] == 4'h2) |-> (!sda_pull && !rx_strobe));

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);

  a_r9_taken_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |-> (state_code == 8'h80));
endmodule

bind i2cs_engine i2cs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .state_code (state_code),
  .sda_pull   (sda_pull),
  .rx_strobe  (rx_strobe),
  .tx_taken   (tx_taken)
);

// File: tb/test_i2cs_engine.sv
`timescale 1ns/1ps
module test_i2cs_engine;
  localparam int Q = 20;
  localparam logic [6:0] OWN7  = 7'h3A;
  localparam logic [9:0] OWN10 = 10'h2C5;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ten_bit_en = 1'b0, tx_valid = 1'b0, nack_next = 1'b0;
  logic [9:0] own_addr = {3'b000, OWN7};
  logic [7:0] tx_byte, rx_byte, state_code;
  logic tx_taken, rx_strobe, sda_pull;
  logic [7:0] tx_mem [64];
  logic [7:0] rx_log [64];
  logic [5:0] tx_idx, rx_n;
  int total = 0, bad = 0;
  bit done = 0;

  wire sda_bus = sda_m & ~sda_pull;
  assign tx_byte = tx_mem[tx_idx];

  always #2 clk = ~clk;

  i2cs_engine i_i2cs_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_m), .sda_in(sda_bus),
    .ten_bit_en(ten_bit_en), .own_addr(own_addr), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_taken(tx_taken), .rx_byte(rx_byte), .rx_strobe(rx_strobe), .nack_next(nack_next),
    .sda_pull(sda_pull), .state_code(state_code)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      tx_idx <= '0;
      rx_n   <= '0;
    end else begin
      if (tx_taken) tx_idx <= tx_idx + 1'b1;
      if (rx_strobe) begin
        rx_log[rx_n] <= rx_byte;
        rx_n <= rx_n + 1'b1;
      end
    end
  end

  function automatic logic [7:0] exp_code(input logic [3:0] maj, input int i);
    return maj[3] ? {maj, 4'(i)} : {maj, 4'h0};
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start(input logic [7:0] exp);
    sda_m = 1'b0; wq();
    chk8("R2 start", state_code, exp);
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart(input logic [7:0] exp);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    chk8("R2 repeated start", state_code, exp);
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
    chk8("R2 stop", state_code, 8'h00);
  endtask

  // Master writes a byte; every high phase checks the state code (R3).
  task automatic byte_w(input logic [7:0] b, input logic [3:0] maj,
                        input logic [7:0] ackcode, output logic ack);
    for (int i = 0; i < 8; i++) begin
      sda_m = b[7-i]; wq();
      scl_m = 1'b1; wq();
      chk8("R3 bit code", state_code, exp_code(maj, i));
      wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_bus;
    chk8("R3 ack code", state_code, ackcode);
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic byte_r(input logic [3:0] maj, input logic mnack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      b[7-i] = sda_bus;
      chk8("R3 tx bit code", state_code, exp_code(maj, i));
      wq();
      scl_m = 1'b0; wq();
    end
    sda_m = mnack; wq();
    scl_m = 1'b1; wq();
    chk8("R3 tx ack code", state_code, exp_code(maj, 8));
    wq();
    scl_m = 1'b0; wq();
  endtask

  // Random 7-bit write transaction, matching or not (R4, R5, R8).
  task automatic wr7(input logic [6:0] a, input int n, input bit match);
    logic ack;
    logic [7:0] d;
    logic [7:0] ex [4];
    logic [5:0] base;
    base = rx_n;
    bus_start(8'h10);
    byte_w({a, 1'b0}, 4'hA, match ? 8'hA8 : 8'h20, ack);
    chk8(match ? "R4 address ack" : "R5 mismatch no ack", {7'd0, ack}, {7'd0, match});
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      ex[k] = d;
      byte_w(d, match ? 4'h9 : 4'h2, match ? 8'h98 : 8'h20, ack);
      chk8(match ? "R8 data ack" : "R5 bystander no ack", {7'd0, ack}, {7'd0, match});
    end
    bus_stop();
    chk8(match ? "R8 strobe count" : "R5 no strobe", 8'(rx_n - base), match ? 8'(n) : 8'd0);
    if (match)
      for (int k = 0; k < n; k++) chk8("R8 rx byte", rx_log[6'(base + 6'(k))], ex[k]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic [5:0] p, rbase;
    void'($urandom(32'h1C2A_5EED));
    for (int k = 0; k < 64; k++) tx_mem[k] = 8'($urandom);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk8("R1 reset code", state_code, 8'h00);
    chk8("R1 reset pull", {7'd0, sda_pull}, 8'h00);

    // R1: disabled block ignores a full address byte
    enable = 1'b0;
    bus_start(8'h00);
    byte_w({OWN7, 1'b0}, 4'h0, 8'h00, ack);
    chk8("R1 disabled no ack", {7'd0, ack}, 8'h00);
    bus_stop();
    enable = 1'b1;
    wq();

    // R11: short SDA pulse while SCL is high is not a START
    sda_m = 1'b0; repeat (2) @(negedge clk); sda_m = 1'b1;
    wq();
    chk8("R11 glitch ignored", state_code, 8'h00);

    // Random 7-bit writes, some addressed elsewhere
    for (int t = 0; t < 8; t++) begin
      bit m;
      logic [6:0] a;
      m = ($urandom % 3) != 0;
      a = m ? OWN7 : 7'($urandom);
      if (!m && a == OWN7) a = a ^ 7'h01;
      wr7(a, 1 + int'($urandom % 4), m);
    end

    // R8: refuse second byte, wait, then repeated START (R2)
    bus_start(8'h10);
    byte_w({OWN7, 1'b0}, 4'hA, 8'hA8, ack);
    byte_w(8'h5A, 4'h9, 8'h98, ack);
    chk8("R8 first byte acked", {7'd0, ack}, 8'h01);
    nack_next = 1'b1;
    byte_w(8'hC3, 4'h9, 8'h98, ack);
    nack_next = 1'b0;
    chk8("R8 refused byte", {7'd0, ack}, 8'h00);
    chk8("R8 wait code", state_code, 8'h30);
    byte_w(8'h11, 4'h3, 8'h30, ack);
    chk8("R8 wait no ack", {7'd0, ack}, 8'h00);
    bus_rstart(8'h10);
    bus_stop();

    // R9/R10: 7-bit read of three bytes
    tx_valid = 1'b1;
    p = tx_idx;
    bus_start(8'h10);
    byte_w({OWN7, 1'b1}, 4'hA, 8'hA8, ack);
    chk8("R4 read address ack", {7'd0, ack}, 8'h01);
    for (int k = 0; k < 3; k++) begin
      byte_r(4'h8, k == 2, b);
      chk8("R9 tx data", b, tx_mem[p]);
      p = p + 1'b1;
    end
    chk8("R10 master nack wait", state_code, 8'h30);
    chk8("R9 taken count", {2'b00, tx_idx}, {2'b00, p});
    bus_stop();

    // R9: nothing valid sends all ones, no handshake
    tx_valid = 1'b0;
    bus_start(8'h10);
    byte_w({OWN7, 1'b1}, 4'hA, 8'hA8, ack);
    byte_r(4'h8, 1'b1, b);
    chk8("R9 empty sends FF", b, 8'hFF);
    chk8("R9 no take", {2'b00, tx_idx}, {2'b00, p});
    bus_stop();

    // R2: STOP in the middle of an address byte
    bus_start(8'h10);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    bus_stop();

    // R6/R7: 10-bit write, repeated START, read
    ten_bit_en = 1'b1;
    own_addr   = OWN10;
    rbase = rx_n;
    bus_start(8'h10);
    byte_w({5'b11110, OWN10[9:8], 1'b0}, 4'hA, 8'hA8, ack);
    chk8("R6 header ack", {7'd0, ack}, 8'h01);
    byte_w(OWN10[7:0], 4'hB, 8'hB8, ack);
    chk8("R6 second byte ack", {7'd0, ack}, 8'h01);
    byte_w(8'h96, 4'h9, 8'h98, ack);
    chk8("R6 data ack", {7'd0, ack}, 8'h01);
    chk8("R6 rx byte", rx_log[rbase], 8'h96);
    tx_valid = 1'b1;
    bus_rstart(8'h10);
    byte_w({5'b11110, OWN10[9:8], 1'b1}, 4'hA, 8'hA8, ack);
    chk8("R7 read header ack", {7'd0, ack}, 8'h01);
    byte_r(4'h8, 1'b1, b);
    chk8("R7 tx data", b, tx_mem[p]);
    chk8("R10 wait after nack", state_code, 8'h30);
    bus_stop();
    tx_valid = 1'b0;

    // R7: read header without an earlier match
    bus_start(8'h10);
    byte_w({5'b11110, OWN10[9:8], 1'b1}, 4'hA, 8'h20, ack);
    chk8("R7 cold read refused", {7'd0, ack}, 8'h00);
    bus_stop();

    // R6: wrong second byte, wrong upper bits
    bus_start(8'h10);
    byte_w({5'b11110, OWN10[9:8], 1'b0}, 4'hA, 8'hA8, ack);
    byte_w(OWN10[7:0] ^ 8'h01, 4'hB, 8'h20, ack);
    chk8("R6 second byte mismatch", {7'd0, ack}, 8'h00);
    bus_stop();
    bus_start(8'h10);
    byte_w({5'b11110, ~OWN10[9:8], 1'b0}, 4'hA, 8'h20, ack);
    chk8("R6 header mismatch", {7'd0, ack}, 8'h00);
    bus_stop();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule